// File: doc/BRIEF.md
# Two-Wire Register Slave with Command Pointer

This block is the serial front end of a small sensor. It listens on an open-drain two-wire bus (clock line and data line, each seen as an input level and driven only as a pull-low enable) and gives a bus master access to a bank of sixteen 8-bit registers that live outside the block. The registers are reached through a plain parallel port: a 4-bit register index, a one-cycle write strobe with its data byte, and a read-data input that the surrounding logic drives from the indexed register.

The slave answers to one 7-bit address picked by a two-bit strap code, and also to the shared alert response address. A written byte whose top bit is set is a command that loads a 4-bit register pointer. Any other written byte is register data. A read with no command first returns the register named by the pointer left from earlier traffic. A working copy of the pointer steps after every data byte, so word and block transfers walk through consecutive registers and wrap at the top of the bank, and a 16-bit value is moved low byte first. Send-byte, receive-byte, byte, word and block writes and reads, plain writes and reads that use a repeated START all reduce to these few rules.

Both bus lines are sampled by the system clock through a synchronizer. The system clock must run at least eight times the bus clock rate.

Top module: `smbus_reg_slave`

## Requirements
- R1: While reset is held, `sdaDriveLow` and `regWrEn` are 0. After reset the stored pointer is 0, so a receive-byte as the first transaction returns register 0.
- R2: The slave acknowledges its own 7-bit address, given by `addrStrap`: 2'b00 gives 0x29, 2'b01 gives 0x49, 2'b10 gives 0x39, and 2'b11 is treated as 2'b00. The address byte is sent MSB first, with the read/write flag as bit 0 (1 = read).
- R3: The alert response address 0x0C is acknowledged for every strap code. A read from it returns the slave's own address in bits 7:1 with bit 0 clear, and repeats that byte for as long as the master acknowledges. A byte written to it is not acknowledged and causes no register write.
- R4: An address that matches neither address is not acknowledged. The slave then keeps `sdaDriveLow` at 0 and makes no register write until the next START.
- R5: A written byte with bit 7 = 1 is a command. It is acknowledged, loads the stored and working pointers with its bits 3:0, and causes no register write.
- R6: A written byte with bit 7 = 0 is data. It is acknowledged and raises `regWrEn` for exactly one cycle, with `regAddr` at the working pointer and `regWrData` equal to the byte.
- R7: The working pointer steps by one after every data byte written to, or read from, the own address, and wraps from 15 to 0.
- R8: The stored pointer keeps its value across STOP. Every START and repeated START copies it into the working pointer, so a receive-byte returns the register it names.
- R9: Read bytes are driven MSB first and change only while SCL is low. When the master acknowledges, the next register follows. When the master does not acknowledge, the slave releases SDA and stays silent until the next START.
- R10: A command byte, then a repeated START and a read, returns the register that the command selected.
- R11: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. Either one cuts off a byte in progress, and a cut-off byte is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Level seen on the bus clock line |
| sdaIn | input | 1 | Level seen on the bus data line |
| sdaDriveLow | output | 1 | 1 pulls the data line low |
| addrStrap | input | 2 | Decoded address strap: 00 low, 01 open, 10 high |
| regAddr | output | 4 | Register index (working pointer) |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Byte to write |
| regRdData | input | 8 | Content of the register at `regAddr` |

## Verification
The register write strobe and the working pointer step fall on the same clock edge. While `regWrEn` is high, `regAddr` must still show the pointer before the step, and the step itself must wrap cleanly from 15 to 0. This case is provoked by a word write that starts at register 15. It is judged by a bench model that queues the expected index and byte for every data byte and compares them on each clock where the strobe is high. A second collision, a STOP arriving in the middle of a byte, is judged by the same model: any unexpected strobe fails, and a later receive-byte must still return the register the earlier command selected.

// File: rtl/smbus_slave_pkg.sv
package smbus_slave_pkg;

  localparam int PTR_W   = 4;
  localparam int BYTE_W  = 8;
  localparam int DEV_W   = 7;
  localparam int BCNT_W  = $clog2(BYTE_W);

  localparam logic [DEV_W-1:0] DEV_ADDR_LOW  = 7'h29;
  localparam logic [DEV_W-1:0] DEV_ADDR_OPEN = 7'h49;
  localparam logic [DEV_W-1:0] DEV_ADDR_HIGH = 7'h39;
  localparam logic [DEV_W-1:0] DEV_ADDR_ALRT = 7'h0C;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR, PH_ADDR_END, PH_ACK_A,
    PH_WR, PH_WR_END, PH_ACK_W,
    PH_RD, PH_RD_END, PH_RD_ACK, PH_RD_LOAD
  } phase_t;

  typedef struct packed {
    logic startTxn;
    logic shiftIn;
    logic cmdLoad;
    logic dataWr;
    logic ptrInc;
    logic loadTx;
    logic nextBit;
    logic ackDrive;
    logic sdaFree;
    logic araSel;
  } strobe_t;

  function automatic logic [DEV_W-1:0] ownAddrOf(input logic [1:0] strap);
    case (strap)
      2'b01:   return DEV_ADDR_OPEN;
      2'b10:   return DEV_ADDR_HIGH;
      default: return DEV_ADDR_LOW;
    endcase
  endfunction

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/smbus_slave_ctrl.sv
module smbus_slave_ctrl
  import smbus_slave_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    startDet,
  input  logic    stopDet,
  input  logic    sdaS,
  input  logic    hitOwn,
  input  logic    hitAra,
  input  logic    rxMsb,
  output strobe_t stb
);

  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W - 1);

  phase_t            phase, phaseNext;
  logic [BCNT_W-1:0] bitCnt, cntNext;
  logic              isRead, readNext;
  logic              isAra, araNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      isRead <= 1'b0;
      isAra  <= 1'b0;
    end else begin
      phase  <= phaseNext;
      bitCnt <= cntNext;
      isRead <= readNext;
      isAra  <= araNext;
    end
  end

  always_comb begin
    stb       = '0;
    phaseNext = phase;
    cntNext   = bitCnt;
    readNext  = isRead;
    araNext   = isAra;
    if (stopDet) begin
      stb.sdaFree = 1'b1;
      phaseNext   = PH_IDLE;
    end else if (startDet) begin
      stb.startTxn = 1'b1;
      stb.sdaFree  = 1'b1;
      phaseNext    = PH_ADDR;
      cntNext      = '0;
    end else begin
      case (phase)
        PH_ADDR: if (sclRise) begin
          stb.shiftIn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            readNext  = sdaS;
            araNext   = hitAra;
            phaseNext = (hitOwn || hitAra) ? PH_ADDR_END : PH_IDLE;
          end else begin
            cntNext = bitCnt + 1'b1;
          end
        end
        PH_ADDR_END: if (sclFall) begin
          stb.ackDrive = 1'b1;
          phaseNext    = PH_ACK_A;
        end
        PH_ACK_A: if (sclFall) begin
          cntNext = '0;
          if (isRead) begin
            stb.loadTx = 1'b1;
            stb.araSel = isAra;
            phaseNext  = PH_RD;
          end else begin
            stb.sdaFree = 1'b1;
            phaseNext   = PH_WR;
          end
        end
        PH_WR: if (sclRise) begin
          stb.shiftIn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            if (isAra) begin
              phaseNext = PH_IDLE;
            end else begin
              stb.cmdLoad = rxMsb;
              stb.dataWr  = ~rxMsb;
              phaseNext   = PH_WR_END;
            end
          end else begin
            cntNext = bitCnt + 1'b1;
          end
        end
        PH_WR_END: if (sclFall) begin
          stb.ackDrive = 1'b1;
          phaseNext    = PH_ACK_W;
        end
        PH_ACK_W: if (sclFall) begin
          stb.sdaFree = 1'b1;
          cntNext     = '0;
          phaseNext   = PH_WR;
        end
        PH_RD: begin
          if (sclRise) begin
            if (bitCnt == LAST_BIT) begin
              stb.ptrInc = ~isAra;
              phaseNext  = PH_RD_END;
            end else begin
              cntNext = bitCnt + 1'b1;
            end
          end
          if (sclFall) stb.nextBit = 1'b1;
        end
        PH_RD_END: if (sclFall) begin
          stb.sdaFree = 1'b1;
          phaseNext   = PH_RD_ACK;
        end
        PH_RD_ACK: if (sclRise) begin
          phaseNext = sdaS ? PH_IDLE : PH_RD_LOAD;
        end
        PH_RD_LOAD: if (sclFall) begin
          stb.loadTx = 1'b1;
          stb.araSel = isAra;
          cntNext    = '0;
          phaseNext  = PH_RD;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/smbus_slave_dp.sv
module smbus_slave_dp
  import smbus_slave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic              sdaS,
  input  logic [1:0]        addrStrap,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              hitOwn,
  output logic              hitAra,
  output logic              rxMsb,
  output logic              sdaDriveLow,
  output logic [PTR_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData
);

  logic [BYTE_W-2:0] shiftReg;
  logic [PTR_W-1:0]  storedPtr;
  logic [PTR_W-1:0]  workPtr;
  logic              sdaLow;
  logic [DEV_W-1:0]  ownAddr;
  logic [BYTE_W-1:0] rxByte;
  logic [BYTE_W-1:0] txByte;

  assign ownAddr = ownAddrOf(addrStrap);
  assign rxByte  = {shiftReg, sdaS};
  assign txByte  = stb.araSel ? {ownAddr, 1'b0} : regRdData;
  assign hitOwn  = (shiftReg == ownAddr);
  assign hitAra  = (shiftReg == DEV_ADDR_ALRT);
  assign rxMsb   = shiftReg[BYTE_W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg  <= '0;
      storedPtr <= '0;
      workPtr   <= '0;
      sdaLow    <= 1'b0;
    end else begin
      if (stb.loadTx)       shiftReg <= txByte[BYTE_W-2:0];
      else if (stb.nextBit) shiftReg <= {shiftReg[BYTE_W-3:0], 1'b0};
      else if (stb.shiftIn) shiftReg <= {shiftReg[BYTE_W-3:0], sdaS};

      if (stb.cmdLoad) storedPtr <= rxByte[PTR_W-1:0];

      if (stb.startTxn)                  workPtr <= storedPtr;
      else if (stb.cmdLoad)              workPtr <= rxByte[PTR_W-1:0];
      else if (stb.dataWr || stb.ptrInc) workPtr <= workPtr + 1'b1;

      if (stb.sdaFree)       sdaLow <= 1'b0;
      else if (stb.ackDrive) sdaLow <= 1'b1;
      else if (stb.loadTx)   sdaLow <= ~txByte[BYTE_W-1];
      else if (stb.nextBit)  sdaLow <= ~shiftReg[BYTE_W-2];
    end
  end

  assign sdaDriveLow = sdaLow;
  assign regAddr     = workPtr;
  assign regWrEn     = stb.dataWr;
  assign regWrData   = rxByte;

endmodule

// File: rtl/smbus_reg_slave.sv
module smbus_reg_slave
  import smbus_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [1:0]        addrStrap,
  output logic [PTR_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData
);

  logic    sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic    hitOwn, hitAra, rxMsb;
  strobe_t stb;

  smbus_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sclS     (sclS),
    .sdaS     (sdaS),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet)
  );

  smbus_slave_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaS     (sdaS),
    .hitOwn   (hitOwn),
    .hitAra   (hitAra),
    .rxMsb    (rxMsb),
    .stb      (stb)
  );

  smbus_slave_dp i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .sdaS        (sdaS),
    .addrStrap   (addrStrap),
    .regRdData   (regRdData),
    .hitOwn      (hitOwn),
    .hitAra      (hitAra),
    .rxMsb       (rxMsb),
    .sdaDriveLow (sdaDriveLow),
    .regAddr     (regAddr),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData)
  );

  logic unusedS;
  assign unusedS = sclS;

endmodule

// File: rtl/smbus_reg_slave_chk.sv
module smbus_reg_slave_chk
  import smbus_slave_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sclIn,
  input logic              sdaDriveLow,
  input logic              regWrEn,
  input logic [PTR_W-1:0]  regAddr,
  input logic [BYTE_W-1:0] regWrData
);

  // R6: a data byte gives a single-cycle strobe
  p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> !regWrEn);

  // R6: the strobe comes from a bit sampled while SCL is high
  p_wr_scl_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |-> sclIn);

  // R5: a byte with its top bit set never reaches the write port
  p_no_cmd_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |-> !regWrData[BYTE_W-1]);

  // R7: the index steps by one, modulo the bank size, after each write
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> regAddr == PTR_W'($past(regAddr) + 1'b1));

  // R9: the slave only starts pulling SDA low while SCL is low
  p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdaDriveLow) |-> !sclIn);

endmodule

bind smbus_reg_slave smbus_reg_slave_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclIn       (sclIn),
  .sdaDriveLow (sdaDriveLow),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData)
);

// File: tb/test_smbus_reg_slave.sv
module test_smbus_reg_slave;

  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclIn = 1'b1;
  logic       mLow = 1'b0;
  logic [1:0] strap = 2'b00;
  logic       silent = 1'b0;
  wire        sdaIn;
  logic       sdaDriveLow;
  logic [3:0] regAddr;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;

  logic [7:0]  bank    [16];
  logic [7:0]  expBank [16];
  logic [11:0] expQ[$];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign sdaIn     = !(mLow || sdaDriveLow);
  assign regRdData = bank[regAddr];

  smbus_reg_slave i_smbus_reg_slave (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaDriveLow(sdaDriveLow), .addrStrap(strap), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );

  // register bank owned by the bench
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) bank[i] <= 8'hA0 + 8'(i);
    end else if (regWrEn) begin
      bank[regAddr] <= regWrData;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model's write queue and silence flag
  always @(negedge clk) begin
    if (rst_n) begin
      if (regWrEn) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R6 unexpected register write", {20'h0, regAddr, regWrData}, 32'h0);
        end else begin
          logic [11:0] e;
          e = expQ.pop_front();
          chk({regAddr, regWrData} == e, "R6 write index/data", {20'h0, regAddr, regWrData}, {20'h0, e});
        end
      end
      if (silent && sdaDriveLow)
        chk(1'b0, "R4/R9 slave must keep SDA released", 32'd1, 32'd0);
    end
  end

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic mStart;
    silent = 1'b0;
    mLow = 1'b0; wq;
    sclIn = 1'b1; wq;
    mLow = 1'b1; wq;
    sclIn = 1'b0; wq;
  endtask

  task automatic mStop;
    mLow = 1'b1; wq;
    sclIn = 1'b1; wq;
    mLow = 1'b0; wq; wq;
  endtask

  task automatic wrBit(input bit b);
    mLow = !b; wq;
    sclIn = 1'b1; wq; wq;
    sclIn = 1'b0; wq;
  endtask

  task automatic rdBit(output bit b);
    mLow = 1'b0; wq;
    sclIn = 1'b1; wq;
    b = sdaIn; wq;
    sclIn = 1'b0; wq;
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) wrBit(v[i]);
    rdBit(a);
    acked = !a;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      rdBit(b);
      v[i] = b;
    end
    wrBit(!ackIt);
  endtask

  task automatic expWr(input logic [3:0] a, input logic [7:0] d);
    expQ.push_back({a, d});
    expBank[a] = d;
  endtask

  initial begin
    bit ack;
    logic [7:0] v;
    for (int i = 0; i < 16; i++) expBank[i] = 8'hA0 + 8'(i);

    repeat (4) @(negedge clk);
    chk(!sdaDriveLow, "R1 SDA released in reset", {31'h0, sdaDriveLow}, 32'h0);
    chk(!regWrEn, "R1 no write strobe in reset", {31'h0, regWrEn}, 32'h0);
    rst_n = 1'b1; wq;

    // R1: first receive-byte reads register 0
    mStart; sendByte(8'h53, ack);
    chk(ack, "R2 strap 00 address read ack", {31'h0, ack}, 32'h1);
    recvByte(1'b0, v);
    chk(v == expBank[0], "R1 pointer 0 after reset", {24'h0, v}, {24'h0, expBank[0]});
    mStop;

    // R5/R6: command then one data byte
    mStart; sendByte(8'h52, ack);
    chk(ack, "R2 strap 00 address write ack", {31'h0, ack}, 32'h1);
    sendByte(8'h83, ack);
    chk(ack, "R5 command byte ack", {31'h0, ack}, 32'h1);
    expWr(4'd3, 8'h5A);
    sendByte(8'h5A, ack);
    chk(ack, "R6 data byte ack", {31'h0, ack}, 32'h1);
    mStop;

    // R8: receive-byte uses the stored pointer
    mStart; sendByte(8'h53, ack); recvByte(1'b0, v);
    chk(v == expBank[3], "R8 receive byte from stored pointer", {24'h0, v}, {24'h0, expBank[3]});
    mStop;

    // R7: word write across the top of the bank
    mStart; sendByte(8'h52, ack); sendByte(8'h8F, ack);
    expWr(4'd15, 8'h11); sendByte(8'h11, ack);
    expWr(4'd0, 8'h22);  sendByte(8'h22, ack);
    chk(ack, "R7 wrapped data byte ack", {31'h0, ack}, 32'h1);
    mStop;

    // R10: combined read with repeated START, low byte first
    mStart; sendByte(8'h52, ack); sendByte(8'h8F, ack);
    mStart; sendByte(8'h53, ack);
    chk(ack, "R10 read address after repeated START", {31'h0, ack}, 32'h1);
    recvByte(1'b1, v);
    chk(v == expBank[15], "R10 first byte from command pointer", {24'h0, v}, {24'h0, expBank[15]});
    recvByte(1'b0, v);
    chk(v == expBank[0], "R7 read pointer wraps to 0", {24'h0, v}, {24'h0, expBank[0]});
    silent = 1'b1; wq; wq;
    mStop;

    // R8: pointer kept across STOP
    mStart; sendByte(8'h53, ack); recvByte(1'b0, v);
    chk(v == expBank[15], "R8 pointer kept across STOP", {24'h0, v}, {24'h0, expBank[15]});
    mStop;

    // R2/R4: strap 01 moves the address
    strap = 2'b01;
    mStart; sendByte(8'h52, ack);
    chk(!ack, "R4 old address not acknowledged", {31'h0, ack}, 32'h0);
    silent = 1'b1;
    sendByte(8'h00, ack);
    chk(!ack, "R4 data after mismatch ignored", {31'h0, ack}, 32'h0);
    mStop;
    mStart; sendByte(8'h92, ack);
    chk(ack, "R2 strap 01 address ack", {31'h0, ack}, 32'h1);
    sendByte(8'h84, ack);
    for (int i = 0; i < 4; i++) begin
      expWr(4'(4 + i), 8'(i + 1));
      sendByte(8'(i + 1), ack);
    end
    mStop;

    // R9: block read, ACK continues, NACK ends
    mStart; sendByte(8'h92, ack); sendByte(8'h84, ack);
    mStart; sendByte(8'h93, ack);
    for (int i = 0; i < 4; i++) begin
      recvByte(i != 3, v);
      chk(v == expBank[4 + i], "R9 block read sequence", {24'h0, v}, {24'h0, expBank[4 + i]});
    end
    silent = 1'b1; wq; wq;
    mStop;

    // R5: send-byte only sets the pointer
    strap = 2'b10;
    mStart; sendByte(8'h72, ack);
    chk(ack, "R2 strap 10 address ack", {31'h0, ack}, 32'h1);
    sendByte(8'h85, ack);
    mStop;
    mStart; sendByte(8'h73, ack); recvByte(1'b0, v);
    chk(v == expBank[5], "R5 send byte sets pointer", {24'h0, v}, {24'h0, expBank[5]});
    mStop;

    // R3: alert address under strap 10
    mStart; sendByte(8'h18, ack);
    chk(ack, "R3 alert address ack strap 10", {31'h0, ack}, 32'h1);
    mStop;

    // R2: strap 11 acts like 00
    strap = 2'b11;
    mStart; sendByte(8'h52, ack);
    chk(ack, "R2 strap 11 acts as 00", {31'h0, ack}, 32'h1);
    mStop;

    // R3: alert reads and writes
    mStart; sendByte(8'h19, ack);
    chk(ack, "R3 alert read ack", {31'h0, ack}, 32'h1);
    recvByte(1'b1, v);
    chk(v == 8'h52, "R3 alert read returns own address", {24'h0, v}, 32'h52);
    recvByte(1'b0, v);
    chk(v == 8'h52, "R3 alert read repeats", {24'h0, v}, 32'h52);
    mStop;
    mStart; sendByte(8'h18, ack);
    sendByte(8'h07, ack);
    chk(!ack, "R3 byte written to alert address NACKed", {31'h0, ack}, 32'h0);
    mStop;

    // R11: STOP in the middle of a data byte
    mStart; sendByte(8'h52, ack); sendByte(8'h82, ack);
    wrBit(1'b0); wrBit(1'b1); wrBit(1'b0); wrBit(1'b1);
    mStop;
    mStart; sendByte(8'h53, ack); recvByte(1'b0, v);
    chk(v == expBank[2], "R11 cut-off byte not written, pointer kept", {24'h0, v}, {24'h0, expBank[2]});
    mStop;

    // R4: non-matching read address
    mStart; sendByte(8'hEF, ack);
    chk(!ack, "R4 foreign read address NACKed", {31'h0, ack}, 32'h0);
    silent = 1'b1;
    recvByte(1'b0, v);
    chk(v == 8'hFF, "R4 bus idle high after mismatch", {24'h0, v}, 32'hFF);
    mStop;

    wq;
    chk(expQ.size() == 0, "R6 every expected write seen", expQ.size(), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule